// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines from peripherals and folds them into one interrupt output for a processor. Each line has its own mask bit in a mask register that software writes and reads through a simple register port. A request on a masked line is not dropped. Because peripherals hold their lines high until they are serviced, the request shows up on the interrupt output once software clears the mask bit, as long as the line is still high.

When the processor acknowledges an interrupt, the block captures the number of the selected request line and presents it as a vector on a data output. If several unmasked lines are high, the lowest-numbered one wins. The vector stays frozen for as long as the acknowledge stays high. At all other times the data output reads zero.

All outputs are registered. Requests, mask state and acknowledge are sampled at the rising clock edge, and each output shows the result one edge later.

Top module: `vint_ctrl`

## Requirements
- R1: While and after reset, the mask readback is all ones, and both the interrupt output and the vector output are zero.
- R2: When the write enable is high at a clock edge, the write data becomes the mask. From the next cycle on, the readback shows it and it gates the requests. Bit i of the mask masks request line i, and a value of 1 means masked.
- R3: After each edge, the interrupt output equals the OR of (request AND NOT mask), where request and mask are the values sampled at that edge.
- R4: A request on a masked line keeps the interrupt output low. If the line is still high when its mask bit is cleared, the interrupt output rises one edge after the mask update.
- R5: When one unmasked line drops, the interrupt output stays high as long as any other unmasked line is still high.
- R6: At the first edge where acknowledge is high after having been low, the block latches the index of the lowest-numbered unmasked active line (0 to N-1). It appears on the vector output after that edge.
- R7: While acknowledge stays high, the vector output does not change, even if requests or the mask change.
- R8: One edge after acknowledge is sampled low, the vector output is zero.
- R9: An acknowledge that rises while no unmasked line is active returns vector 0.
- R10: When the write enable is low, the mask does not change, whatever is on the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_LINES | Level-sensitive request lines, bit i = line i |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_wr_data | input | N_LINES | Mask value to write, 1 = masked |
| reg_rd_data | output | N_LINES | Current mask register value |
| irq_out | output | 1 | Combined interrupt to the processor |
| ack_in | input | 1 | Processor interrupt acknowledge |
| vec_out | output | $clog2(N_LINES) | Latched vector during acknowledge, zero otherwise |

## Verification
The bench builds the block with the default of eight lines, which gives a 3-bit vector. At that size both ends of the priority chain can be reached: line 0 beats every other line, and line 7 wins only when it is alone. It also makes it practical to cover every mask bit with single writes. A behavioural model running in step with the block predicts the mask, the interrupt output and the vector on every cycle. The stimulus covers pending-while-masked requests, overlapping requests, requests that change during an acknowledge, and an acknowledge with nothing pending.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned INTC_DEF_LINES = 8;

  function automatic int unsigned intc_vec_width(input int unsigned lines);
    return (lines < 2) ? 1 : $clog2(lines);
  endfunction
endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned N_LINES = intc_pkg::INTC_DEF_LINES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en) begin
      mask_q <= wr_data;
    end
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int unsigned N_LINES = intc_pkg::INTC_DEF_LINES,
  localparam int unsigned VW = intc_pkg::intc_vec_width(N_LINES)
) (
  input  logic [N_LINES-1:0] pend,
  output logic               any,
  output logic [VW-1:0]      idx
);
  logic [N_LINES:0]   seen;
  logic [N_LINES-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_LINES; i++) begin : g_chain
    assign grant[i]  = pend[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pend[i];
  end

  assign any = seen[N_LINES];

  always_comb begin
    idx = '0;
    for (int unsigned i = 0; i < N_LINES; i++) begin
      if (grant[i]) idx = VW'(i);
    end
  end
endmodule

// File: rtl/intc_vec_latch.sv
module intc_vec_latch #(
  parameter int unsigned VW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack,
  input  logic          any,
  input  logic [VW-1:0] idx,
  output logic [VW-1:0] vec_q
);
  logic ack_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_d <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_d <= ack;
      if (!ack) begin
        vec_q <= '0;
      end else if (!ack_d) begin
        vec_q <= any ? idx : '0;
      end
    end
  end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl #(
  parameter int unsigned N_LINES = intc_pkg::INTC_DEF_LINES,
  localparam int unsigned VW = intc_pkg::intc_vec_width(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic               reg_wr_en,
  input  logic [N_LINES-1:0] reg_wr_data,
  output logic [N_LINES-1:0] reg_rd_data,
  output logic               irq_out,
  input  logic               ack_in,
  output logic [VW-1:0]      vec_out
);
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pend;
  logic               any_pend;
  logic [VW-1:0]      low_idx;
  logic               irq_q;

  intc_mask_reg #(.N_LINES(N_LINES)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr_en),
    .wr_data(reg_wr_data),
    .mask_q (mask_q)
  );

  assign pend = req_in & ~mask_q;

  intc_prio_enc #(.N_LINES(N_LINES)) u_prio (
    .pend(pend),
    .any (any_pend),
    .idx (low_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_pend;
  end

  intc_vec_latch #(.VW(VW)) u_vec (
    .clk  (clk),
    .rst  (rst),
    .ack  (ack_in),
    .any  (any_pend),
    .idx  (low_idx),
    .vec_q(vec_out)
  );

  assign reg_rd_data = mask_q;
  assign irq_out     = irq_q;
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VW = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] req_in,
  input logic               reg_wr_en,
  input logic [N_LINES-1:0] reg_wr_data,
  input logic [N_LINES-1:0] reg_rd_data,
  input logic               irq_out,
  input logic               ack_in,
  input logic [VW-1:0]      vec_out
);
  logic [1:0] pv;
  always_ff @(posedge clk) begin
    if (rst) pv <= '0;
    else     pv <= {pv[0], 1'b1};
  end

  function automatic logic [VW-1:0] lowest(input logic [N_LINES-1:0] p);
    lowest = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (p[i]) lowest = VW'(i);
    end
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (reg_rd_data == '1) && !irq_out && (vec_out == '0)); // R1
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> reg_rd_data == $past(reg_wr_data)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pv[0] && !reg_wr_en) |=> $stable(reg_rd_data)); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pv[0] |=> irq_out == $past(|(req_in & ~reg_rd_data))); // R3
  AST_VEC_PICK: assert property (@(posedge clk) disable iff (rst)
    (pv[1] && ack_in && !$past(ack_in)) |=> vec_out == $past(lowest(req_in & ~reg_rd_data))); // R6
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pv[1] && ack_in && $past(ack_in)) |=> $stable(vec_out)); // R7
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pv[0] && !ack_in) |=> vec_out == '0); // R8
endmodule

bind vint_ctrl vint_ctrl_chk #(.N_LINES(N_LINES), .VW(VW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_in     (req_in),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_data(reg_wr_data),
  .reg_rd_data(reg_rd_data),
  .irq_out    (irq_out),
  .ack_in     (ack_in),
  .vec_out    (vec_out)
);

// File: tb/vint_ctrl_test.sv
`timescale 1ns/100ps
module vint_ctrl_test;
  localparam int N = 8;
  localparam int VW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_in = '0;
  logic          reg_wr_en = 1'b0;
  logic [N-1:0]  reg_wr_data = '0;
  logic [N-1:0]  reg_rd_data;
  logic          irq_out;
  logic          ack_in = 1'b0;
  logic [VW-1:0] vec_out;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  vint_ctrl #(.N_LINES(N)) uut (
    .clk(clk), .rst(rst), .req_in(req_in), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .irq_out(irq_out),
    .ack_in(ack_in), .vec_out(vec_out)
  );

  // behavioural model
  int m_mask = 255;
  int m_irq = 0;
  int m_vec = 0;
  int m_ackd = 0;

  always @(posedge clk) begin
    int pend;
    int low;
    if (rst) begin
      m_mask = 255; m_irq = 0; m_vec = 0; m_ackd = 0;
    end else begin
      pend = int'(req_in) & ~m_mask & 255;
      low = 0;
      for (int i = N - 1; i >= 0; i--) if (pend[i]) low = i;
      m_irq = (pend != 0) ? 1 : 0;
      if (!ack_in) m_vec = 0;
      else if (m_ackd == 0) m_vec = low;
      m_ackd = ack_in ? 1 : 0;
      if (reg_wr_en) m_mask = int'(reg_wr_data);
    end
  end

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "mask", int'(reg_rd_data), m_mask);
    chk(tag, "irq", int'(irq_out), m_irq);
    chk(tag, "vec", int'(vec_out), m_vec);
  endtask

  // one cycle: compare at negedge, then drive next inputs
  task automatic cyc(input logic [N-1:0] r, input logic we, input logic [N-1:0] wd, input logic a);
    @(negedge clk);
    compare_all();
    req_in = r; reg_wr_en = we; reg_wr_data = wd; ack_in = a;
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "reset mask", int'(reg_rd_data), 255);
    chk("R1", "reset irq", int'(irq_out), 0);
    chk("R1", "reset vec", int'(vec_out), 0);
    rst = 1'b0;
    cyc('0, 0, '0, 0);

    // R4: pending while masked, released by unmask
    tag = "R4";
    cyc(8'h20, 0, '0, 0);
    cyc(8'h20, 0, '0, 0);
    cyc(8'h20, 0, '0, 0);
    cyc(8'h20, 1, 8'hDF, 0);
    cyc(8'h20, 0, '0, 0);
    cyc(8'h20, 0, '0, 0);
    chk("R4", "irq after unmask", int'(irq_out), 1);

    // R2 / R10: mask write and hold
    tag = "R2";
    cyc(8'h00, 1, 8'h5A, 0);
    cyc(8'h00, 0, 8'hFF, 0);
    chk("R2", "readback", int'(reg_rd_data), 8'h5A);
    tag = "R10";
    cyc(8'h00, 0, 8'h00, 0);
    cyc(8'h00, 0, 8'h33, 0);
    cyc(8'h00, 0, 8'h00, 0);
    chk("R10", "mask held", int'(reg_rd_data), 8'h5A);

    // R3: combined output follows unmasked requests
    tag = "R3";
    cyc(8'h5A, 0, '0, 0);
    cyc(8'hA5, 0, '0, 0);
    cyc(8'hA5, 0, '0, 0);
    chk("R3", "unmasked active", int'(irq_out), 1);
    cyc(8'h5A, 0, '0, 0);
    cyc(8'h5A, 0, '0, 0);
    chk("R3", "only masked active", int'(irq_out), 0);

    // R5: overlapping requests
    tag = "R5";
    cyc(8'h00, 1, 8'h00, 0);
    cyc(8'h06, 0, '0, 0);
    cyc(8'h04, 0, '0, 0);
    cyc(8'h04, 0, '0, 0);
    chk("R5", "irq kept by other line", int'(irq_out), 1);
    cyc(8'h00, 0, '0, 0);
    cyc(8'h00, 0, '0, 0);

    // R6: lowest unmasked wins (mask line 3)
    tag = "R6";
    cyc(8'hA8, 1, 8'h08, 0);
    cyc(8'hA8, 0, '0, 1);
    cyc(8'hA8, 0, '0, 1);
    chk("R6", "vector", int'(vec_out), 5);

    // R7: hold while ack high despite changes
    tag = "R7";
    cyc(8'h01, 0, '0, 1);
    cyc(8'h01, 1, 8'h00, 1);
    cyc(8'h81, 0, '0, 1);
    cyc(8'h81, 0, '0, 1);
    chk("R7", "held vector", int'(vec_out), 5);

    // R8: zero after ack low
    tag = "R8";
    cyc(8'h81, 0, '0, 0);
    cyc(8'h81, 0, '0, 0);
    chk("R8", "idle vector", int'(vec_out), 0);

    // R6 boundaries: line 0 beats all, line 7 alone
    tag = "R6";
    cyc(8'hFF, 0, '0, 1);
    cyc(8'hFF, 0, '0, 1);
    chk("R6", "line 0 wins", int'(vec_out), 0);
    cyc(8'h80, 0, '0, 0);
    cyc(8'h80, 0, '0, 1);
    cyc(8'h80, 0, '0, 1);
    chk("R6", "line 7 alone", int'(vec_out), 7);
    cyc(8'h00, 0, '0, 0);

    // R9: ack with nothing pending
    tag = "R9";
    cyc(8'h10, 1, 8'h10, 0);
    cyc(8'h10, 0, '0, 1);
    cyc(8'h10, 0, '0, 1);
    chk("R9", "spurious vector", int'(vec_out), 0);
    chk("R9", "irq low", int'(irq_out), 0);
    cyc(8'h00, 0, '0, 0);

    // R2: walk every mask bit
    tag = "R2";
    for (int b = 0; b < N; b++) begin
      cyc(8'h00, 1, ~(8'h01 << b), 0);
      cyc(8'h01 << b, 0, '0, 0);
      cyc(8'h01 << b, 0, '0, 1);
      cyc(8'h00, 0, '0, 1);
      chk("R2", "single line vector", int'(vec_out), b);
      cyc(8'h00, 0, '0, 0);
    end

    // R1: reset mid-run
    tag = "R1";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset mask", int'(reg_rd_data), 255);
    chk("R1", "reset irq", int'(irq_out), 0);
    rst = 1'b0;
    cyc('0, 0, '0, 0);
    cyc('0, 0, '0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule